// File: doc/BRIEF.md
# Software-Generated Interrupt Acceptance Filter

This block sits between the delivery path for software-generated interrupts (SGIs) and the pending state of one processor. A request names one of 16 SGI numbers, a requested group and whether the originator is non-secure. The block checks the request against the configured group of the SGI. For non-secure requests it also checks a 2-bit permission level per SGI, taken from a 32-bit access control word. If the request passes, the pending bit of that SGI is set. If it fails, the request is dropped.

A request arrives as a single-cycle valid pulse. The accept or reject outcome appears as a one-cycle strobe one clock later, on the same edge that updates the pending vector. A separate clear input removes pending bits and takes priority over a set of the same bit in the same cycle.

Reset is asynchronous, active low, and its release is synchronised inside the block. The block ignores inputs until two clock edges after `rst_n` rises.

Top module: `sgi_accept_filter`

## Requirements
- R1: While reset is active, and after reset until the first request, `pend` is all zeros and both `acc_pulse` and `rej_pulse` are low.
- R2: A group 1 request (`req_grp1`=1) aimed at an SGI configured as group 0 (`cfg_grp1[n]`=0) is handled as a group 0 request. Subject to the permission check, it is accepted.
- R3: A group 0 request (`req_grp1`=0) aimed at an SGI configured as group 1 (`cfg_grp1[n]`=1) is rejected.
- R4: The permission level of SGI n is the unsigned value `ns_perm[2n+1:2n]`. Only the field of the requested SGI affects the outcome.
- R5: When `sec_off`=0 and `req_ns`=1, the request is rejected in two cases: a group 0 SGI whose permission level is below 1, or a group 1 SGI whose permission level is below 2.
- R6: When `sec_off`=1, or when `req_ns`=0, the permission level is not consulted; the group rules alone decide.
- R7: A request with `req_valid` high produces exactly one of `acc_pulse` or `rej_pulse`, high for one cycle, in the cycle after the request. No strobe occurs without a request.
- R8: An accepted request for SGI n sets `pend[n]` on the same edge as `acc_pulse` rises. Other pending bits are left unchanged, and a rejected request changes no pending bit.
- R9: When `clr_valid`=1, every bit set in `clr_mask` is cleared on the next edge. A clear wins over an accept for the same bit in the same cycle, while `acc_pulse` still reports the acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle pulse: an SGI request is present |
| req_id | input | 4 | Requested SGI number, 0 to 15 |
| req_grp1 | input | 1 | Requested group: 0 = group 0, 1 = group 1 |
| req_ns | input | 1 | 1 = request from the non-secure side |
| cfg_grp1 | input | 16 | Configured group per SGI: bit n = 1 means group 1 |
| ns_perm | input | 32 | Per-SGI 2-bit non-secure permission levels |
| sec_off | input | 1 | 1 = security disabled, permission check skipped |
| clr_valid | input | 1 | Apply `clr_mask` to the pending vector |
| clr_mask | input | 16 | Pending bits to clear |
| acc_pulse | output | 1 | Request of the previous cycle was accepted |
| rej_pulse | output | 1 | Request of the previous cycle was rejected |
| pend | output | 16 | Pending bit per SGI |

## Verification
The assertions assume that the configuration inputs (`cfg_grp1`, `ns_perm`, `sec_off`) are stable across the cycle in which a request is registered. They also assume that requests are presented only after the internal reset release.

The stimulus meets both assumptions. It drives every input on the falling clock edge and holds it for a full cycle. It waits several cycles after reset before the first request.

Each sweep point clears all pending bits first, so a stale bit cannot hide a missing set. Configuration values for the SGIs that are not requested are filled with the complement of the requested one, so a decode of the wrong field or group bit changes the outcome.

// File: rtl/sgi_filt_pkg.sv
package sgi_filt_pkg;
  localparam int unsigned SGI_COUNT  = 16;
  localparam int unsigned LEVEL_BITS = 2;

  typedef enum logic [LEVEL_BITS-1:0] {
    LVL_NONE  = 2'd0,
    LVL_G0    = 2'd1,
    LVL_G0_G1 = 2'd2,
    LVL_FULL  = 2'd3
  } perm_lvl_e;

  typedef struct packed {
    logic accept;
    logic reject;
  } verdict_t;

  // Lowest permission level a non-secure request needs for the given group.
  function automatic logic [LEVEL_BITS-1:0] min_level(input logic is_grp1);
    return is_grp1 ? LVL_G0_G1 : LVL_G0;
  endfunction
endpackage

// File: rtl/sgi_rst_sync.sv
module sgi_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/sgi_grp_match.sv
module sgi_grp_match #(
  parameter int unsigned NUM_SGI = 16,
  localparam int unsigned ID_W   = $clog2(NUM_SGI)
) (
  input  logic [ID_W-1:0]    req_id,
  input  logic               req_grp1,
  input  logic [NUM_SGI-1:0] cfg_grp1,
  output logic               tgt_grp1,
  output logic               grp_ok
);
  logic eff_grp1;

  always_comb begin
    tgt_grp1 = cfg_grp1[req_id];
    // Group 1 asked of a group 0 target is demoted to group 0.
    eff_grp1 = req_grp1 & tgt_grp1;
    grp_ok   = (eff_grp1 == tgt_grp1);
  end
endmodule

// File: rtl/sgi_perm_gate.sv
module sgi_perm_gate
  import sgi_filt_pkg::*;
#(
  parameter int unsigned NUM_SGI = 16,
  localparam int unsigned ID_W   = $clog2(NUM_SGI),
  localparam int unsigned ACW    = NUM_SGI * LEVEL_BITS
) (
  input  logic [ID_W-1:0] req_id,
  input  logic [ACW-1:0]  ns_perm,
  input  logic            req_ns,
  input  logic            sec_off,
  input  logic            tgt_grp1,
  output logic            perm_ok
);
  logic [LEVEL_BITS-1:0] lvl [NUM_SGI];
  logic [LEVEL_BITS-1:0] sel_lvl;
  logic                  need_chk;

  for (genvar g = 0; g < NUM_SGI; g++) begin : g_field
    assign lvl[g] = ns_perm[g*LEVEL_BITS +: LEVEL_BITS];
  end

  always_comb begin
    sel_lvl  = lvl[req_id];
    need_chk = req_ns & ~sec_off;
    perm_ok  = !need_chk || (sel_lvl >= min_level(tgt_grp1));
  end
endmodule

// File: rtl/sgi_pend_bank.sv
module sgi_pend_bank #(
  parameter int unsigned NUM_SGI = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SGI-1:0] set_vec,
  input  logic [NUM_SGI-1:0] clr_vec,
  output logic [NUM_SGI-1:0] pend
);
  logic [NUM_SGI-1:0] pend_q;
  logic [NUM_SGI-1:0] pend_d;

  for (genvar b = 0; b < NUM_SGI; b++) begin : g_bit
    logic en;
    always_comb begin
      en = set_vec[b] | clr_vec[b];
      pend_d[b] = en ? (set_vec[b] & ~clr_vec[b]) : pend_q[b];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pend_q[b] <= 1'b0;
      else if (en) pend_q[b] <= pend_d[b];
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/sgi_accept_filter.sv
module sgi_accept_filter
  import sgi_filt_pkg::*;
#(
  parameter int unsigned NUM_SGI = SGI_COUNT,
  localparam int unsigned ID_W   = $clog2(NUM_SGI),
  localparam int unsigned ACW    = NUM_SGI * LEVEL_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ID_W-1:0]    req_id,
  input  logic               req_grp1,
  input  logic               req_ns,
  input  logic [NUM_SGI-1:0] cfg_grp1,
  input  logic [ACW-1:0]     ns_perm,
  input  logic               sec_off,
  input  logic               clr_valid,
  input  logic [NUM_SGI-1:0] clr_mask,
  output logic               acc_pulse,
  output logic               rej_pulse,
  output logic [NUM_SGI-1:0] pend
);
  logic               rst_sync_n;
  logic               tgt_grp1;
  logic               grp_ok;
  logic               perm_ok;
  verdict_t           verdict_d;
  verdict_t           verdict_q;
  logic [NUM_SGI-1:0] set_vec;
  logic [NUM_SGI-1:0] clr_vec;

  sgi_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  sgi_grp_match #(.NUM_SGI(NUM_SGI)) u_grp (
    .req_id   (req_id),
    .req_grp1 (req_grp1),
    .cfg_grp1 (cfg_grp1),
    .tgt_grp1 (tgt_grp1),
    .grp_ok   (grp_ok)
  );

  sgi_perm_gate #(.NUM_SGI(NUM_SGI)) u_perm (
    .req_id   (req_id),
    .ns_perm  (ns_perm),
    .req_ns   (req_ns),
    .sec_off  (sec_off),
    .tgt_grp1 (tgt_grp1),
    .perm_ok  (perm_ok)
  );

  always_comb begin
    verdict_d.accept = req_valid & grp_ok & perm_ok;
    verdict_d.reject = req_valid & ~(grp_ok & perm_ok);
    clr_vec          = clr_valid ? clr_mask : '0;
  end

  for (genvar s = 0; s < NUM_SGI; s++) begin : g_set
    assign set_vec[s] = verdict_d.accept && (req_id == ID_W'(s));
  end

  sgi_pend_bank #(.NUM_SGI(NUM_SGI)) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .pend    (pend)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) verdict_q <= '0;
    else             verdict_q <= verdict_d;
  end

  assign acc_pulse = verdict_q.accept;
  assign rej_pulse = verdict_q.reject;
endmodule

// File: rtl/sgi_accept_filter_chk.sv
module sgi_accept_filter_chk #(
  parameter int unsigned NUM_SGI = 16,
  localparam int unsigned ID_W   = $clog2(NUM_SGI),
  localparam int unsigned ACW    = NUM_SGI * 2
) (
  input logic               clk,
  input logic               live_n,
  input logic               req_valid,
  input logic [ID_W-1:0]    req_id,
  input logic               req_grp1,
  input logic               req_ns,
  input logic [NUM_SGI-1:0] cfg_grp1,
  input logic [ACW-1:0]     ns_perm,
  input logic               sec_off,
  input logic               clr_valid,
  input logic [NUM_SGI-1:0] clr_mask,
  input logic               acc_pulse,
  input logic               rej_pulse,
  input logic [NUM_SGI-1:0] pend
);
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!live_n)
    req_valid |=> (acc_pulse ^ rej_pulse)); // R7
  AST_NO_STRAY_VERDICT: assert property (@(posedge clk) disable iff (!live_n)
    !req_valid |=> !(acc_pulse || rej_pulse)); // R7
  AST_GRP_MISMATCH: assert property (@(posedge clk) disable iff (!live_n)
    (req_valid && !req_grp1 && cfg_grp1[req_id]) |=> rej_pulse); // R3
  AST_NS_NO_LEVEL: assert property (@(posedge clk) disable iff (!live_n)
    (req_valid && req_ns && !sec_off && ns_perm[{req_id, 1'b0} +: 2] == 2'd0) |=> rej_pulse); // R5
  AST_ACC_SETS_BIT: assert property (@(posedge clk) disable iff (!live_n)
    acc_pulse |-> (pend[$past(req_id)] || $past(clr_valid && clr_mask[req_id]))); // R8
  AST_NO_SPONT_SET: assert property (@(posedge clk) disable iff (!live_n)
    ((pend & ~$past(pend)) != '0) |-> acc_pulse); // R8
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!live_n)
    clr_valid |=> ((pend & $past(clr_mask)) == '0)); // R9
endmodule

bind sgi_accept_filter sgi_accept_filter_chk #(.NUM_SGI(NUM_SGI)) u_chk (
  .clk       (clk),
  .live_n    (rst_sync_n),
  .req_valid (req_valid),
  .req_id    (req_id),
  .req_grp1  (req_grp1),
  .req_ns    (req_ns),
  .cfg_grp1  (cfg_grp1),
  .ns_perm   (ns_perm),
  .sec_off   (sec_off),
  .clr_valid (clr_valid),
  .clr_mask  (clr_mask),
  .acc_pulse (acc_pulse),
  .rej_pulse (rej_pulse),
  .pend      (pend)
);

// File: tb/sgi_accept_filter_tb_top.sv
module sgi_accept_filter_tb_top;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [3:0]  req_id;
  logic        req_grp1;
  logic        req_ns;
  logic [15:0] cfg_grp1;
  logic [31:0] ns_perm;
  logic        sec_off;
  logic        clr_valid;
  logic [15:0] clr_mask;
  logic        acc_pulse;
  logic        rej_pulse;
  logic [15:0] pend;

  int n_chk;
  int n_bad;
  int cyc;
  bit done;

  sgi_accept_filter dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
    .req_grp1(req_grp1), .req_ns(req_ns), .cfg_grp1(cfg_grp1),
    .ns_perm(ns_perm), .sec_off(sec_off), .clr_valid(clr_valid),
    .clr_mask(clr_mask), .acc_pulse(acc_pulse), .rej_pulse(rej_pulse),
    .pend(pend)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit model_ok(input bit rg, input bit cg, input bit ns,
                                  input bit so, input int lvl);
    bit eg;
    eg = rg & cg;
    if (eg != cg) return 1'b0;
    if (ns && !so) return cg ? (lvl >= 2) : (lvl >= 1);
    return 1'b1;
  endfunction

  task automatic idle_inputs();
    req_valid = 0; req_id = '0; req_grp1 = 0; req_ns = 0;
    clr_valid = 0; clr_mask = '0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    idle_inputs();
    clr_valid = 1; clr_mask = 16'hFFFF;
    @(negedge clk);
    idle_inputs();
  endtask

  // Drive a request for one cycle; outputs are sampled at the next falling edge.
  task automatic pulse_req(input int id, input bit rg, input bit ns);
    @(negedge clk);
    req_valid = 1; req_id = 4'(id); req_grp1 = rg; req_ns = ns;
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    idle_inputs();
    cfg_grp1 = '0; ns_perm = '0; sec_off = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 pend in reset", 32'(pend), 0);
    check("R1 strobes in reset", {30'd0, acc_pulse, rej_pulse}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 pend after reset", 32'(pend), 0);
    check("R1 strobes after reset", {30'd0, acc_pulse, rej_pulse}, 0);

    // Exhaustive sweep: R2 R3 R4 R5 R6 R7 R8
    for (int id = 0; id < 16; id++)
      for (int rg = 0; rg < 2; rg++)
        for (int cg = 0; cg < 2; cg++)
          for (int ns = 0; ns < 2; ns++)
            for (int so = 0; so < 2; so++)
              for (int lv = 0; lv < 4; lv++) begin
                bit ok;
                ok = model_ok(rg[0], cg[0], ns[0], so[0], lv);
                clear_all();
                cfg_grp1 = cg[0] ? 16'h0000 : 16'hFFFF;
                cfg_grp1[id] = cg[0];
                for (int k = 0; k < 16; k++) ns_perm[2*k +: 2] = 2'(3 - lv);
                ns_perm[2*id +: 2] = 2'(lv);
                sec_off = so[0];
                pulse_req(id, rg[0], ns[0]);
                check($sformatf("R7 verdict id=%0d rg=%0d cg=%0d ns=%0d so=%0d lv=%0d R2 R3 R4 R5 R6",
                                id, rg, cg, ns, so, lv),
                      {30'd0, acc_pulse, rej_pulse}, ok ? 32'd2 : 32'd1);
                check($sformatf("R8 pend id=%0d", id), 32'(pend),
                      ok ? (32'd1 << id) : 32'd0);
                @(negedge clk);
                check("R7 strobe one cycle", {30'd0, acc_pulse, rej_pulse}, 0);
              end

    // R8: pending accumulates, other bits kept
    cfg_grp1 = '0; sec_off = 1;
    clear_all();
    pulse_req(3, 0, 0);
    pulse_req(12, 1, 1);
    check("R8 accumulate", 32'(pend), 32'h1008);
    // R9: clear of a different bit alongside accept
    @(negedge clk);
    req_valid = 1; req_id = 4'd5; clr_valid = 1; clr_mask = 16'h0008;
    @(negedge clk);
    idle_inputs();
    check("R9 clear other bit", 32'(pend), 32'h1020);
    // R9: clear wins over accept of same bit; accept still reported
    @(negedge clk);
    req_valid = 1; req_id = 4'd7; clr_valid = 1; clr_mask = 16'h0080;
    @(negedge clk);
    idle_inputs();
    check("R9 clear wins", 32'(pend), 32'h1020);
    check("R9 acc still strobed", {31'd0, acc_pulse}, 1);
    // R8: rejected request leaves pending untouched
    cfg_grp1 = 16'hFFFF;
    pulse_req(9, 0, 0);
    check("R8 reject leaves pend", 32'(pend), 32'h1020);
    check("R3 reject strobe", {31'd0, rej_pulse}, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end
endmodule